// File: doc/BRIEF.md
# Parallel Poll Response Unit

This block decides, for an instrument-bus device, whether it answers a parallel poll and on which of the eight data lines. A small configuration word holds three things: an opt-out flag, the expected status polarity, and a 3-bit line index. The word is loaded in one of two ways. The host can write it locally, or the controller can program it remotely with enable, disable and unconfigure command bytes.

The status bit compared against the polarity has two possible sources. One is a register that software sets and clears with pulses. The other is the live service-request condition of the device. A select input picks between them.

While the controller sends the identify message (ATN and EOI both true), the unit registers an 8-bit line drive mask. It also raises a mode flag that switches the bus transceivers from three-state to open-collector for the length of the response. Both outputs appear one clock after the inputs they depend on.

Top module: `ppoll_responder`

## Requirements
- R1: After reset the configuration word is zero (opt-out clear, polarity 0, line 0) and the software status bit is 0. Both outputs are 0 while reset is held. The first identify after reset therefore drives only bit 0 (DIO1).
- R2: A local write loads the configuration from `cfg_wdata`: bit 4 is the opt-out flag, bit 3 is the polarity, and bits 2:0 are the line index. Bits 7:5 are ignored.
- R3: One cycle after a cycle with ATN=1 and EOI=1, `dio_drive` is one-hot at bit index equal to the line index, provided the opt-out flag is 0 and the effective status equals the polarity.
- R4: `dio_drive` is all zero one cycle after any cycle in which ATN or EOI is low, the opt-out flag is 1, or the status differs from the polarity.
- R5: `oc_mode` equals ATN AND EOI of the previous cycle. Any nonzero `dio_drive` comes with `oc_mode` high.
- R6: A command byte of the form 0110 S P2 P1 P0, received while `ppcs` is high, clears the opt-out flag and loads polarity S and line P. Such a byte is ignored while `ppcs` is low.
- R7: A command byte 0111xxxx received while `ppcs` is high sets the opt-out flag. The byte 0x15 sets the opt-out flag regardless of `ppcs`. Polarity and line are kept in both cases.
- R8: A local write and a remote command in the same cycle resolve to the local write.
- R9: With `ist_sel`=0 the status is the software bit, set by `ist_set` and cleared by `ist_clr`. If both pulse in the same cycle, set wins.
- R10: With `ist_sel`=1 the status is `srq_state` AND `srq_active`, taken live. The software bit is still updated but has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Local configuration write strobe |
| cfg_wdata | input | 8 | Local configuration data |
| cmd_valid | input | 1 | Received command byte strobe |
| cmd_byte | input | 8 | Received command byte |
| ppcs | input | 1 | Device is in the remote poll-configure state |
| ist_sel | input | 1 | Status source select (0 software, 1 service request) |
| ist_set | input | 1 | Software status set pulse |
| ist_clr | input | 1 | Software status clear pulse |
| srq_state | input | 1 | Service-request function is in its request state |
| srq_active | input | 1 | Device is asserting SRQ |
| atn | input | 1 | ATN line, active high |
| eoi | input | 1 | EOI line, active high |
| dio_drive | output | 8 | Data line drive mask, bit 0 is DIO1 |
| oc_mode | output | 1 | Transceivers in open-collector mode |

## Verification
The bench targets several collisions and partial conditions:
- A local write landing in the same cycle as a remote enable. A design that favoured the remote byte would drive the wrong line.
- Simultaneous set and clear pulses. Wrong priority leaves the status at 0, and the device then drives for the opposite polarity.
- Half identify cycles (ATN alone, EOI alone). A design that decoded only ATN would drive during ordinary commands.
- Enable bytes sent while `ppcs` is low, and the unconfigure byte 0x15 sent while it is low. A careless decoder would accept the first and ignore the second.
- Switching the status source to the service-request inputs while the software bit disagrees. This exposes a design that keeps using the stored bit.

// File: rtl/ppoll_pkg.sv
package ppoll_pkg;
  localparam int DIO_W  = 8;
  localparam int LINE_W = $clog2(DIO_W);
  localparam int CFG_W  = LINE_W + 2;

  // configuration word, packed in local-write bit order
  typedef struct packed {
    logic              unconf;
    logic              sense;
    logic [LINE_W-1:0] line;
  } ppcfg_t;

  localparam logic [7:0] CMD_UNCONF = 8'h15;
  localparam logic [3:0] GRP_ENABLE = 4'h6;
  localparam logic [3:0] GRP_DISABLE = 4'h7;
endpackage

// File: rtl/ppoll_cfg_reg.sv
module ppoll_cfg_reg
  import ppoll_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [7:0]   cfg_wdata,
  input  logic         cmd_valid,
  input  logic [7:0]   cmd_byte,
  input  logic         ppcs,
  output ppcfg_t       cfg_q
);
  ppcfg_t cfg_d;
  logic   cfg_en;
  logic   hit_enable, hit_disable, hit_unconf;

  always_comb begin
    hit_unconf  = cmd_valid && (cmd_byte == CMD_UNCONF);
    hit_enable  = cmd_valid && ppcs && (cmd_byte[7:4] == GRP_ENABLE);
    hit_disable = cmd_valid && ppcs && (cmd_byte[7:4] == GRP_DISABLE);
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (cfg_wr) begin
      cfg_d  = ppcfg_t'(cfg_wdata[CFG_W-1:0]);
      cfg_en = 1'b1;
    end else if (hit_enable) begin
      cfg_d.unconf = 1'b0;
      cfg_d.sense  = cmd_byte[LINE_W];
      cfg_d.line   = cmd_byte[LINE_W-1:0];
      cfg_en       = 1'b1;
    end else if (hit_disable || hit_unconf) begin
      cfg_d.unconf = 1'b1;
      cfg_en       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/ppoll_ist_src.sv
module ppoll_ist_src (
  input  logic clk,
  input  logic rst_n,
  input  logic ist_sel,
  input  logic ist_set,
  input  logic ist_clr,
  input  logic srq_state,
  input  logic srq_active,
  output logic ist_eff
);
  logic sw_q, sw_d, sw_en;

  always_comb begin
    sw_en = ist_set || ist_clr;
    sw_d  = ist_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= 1'b0;
    else if (sw_en) sw_q <= sw_d;
  end

  always_comb ist_eff = ist_sel ? (srq_state && srq_active) : sw_q;
endmodule

// File: rtl/ppoll_drive.sv
module ppoll_drive
  import ppoll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ppcfg_t           cfg,
  input  logic             ist_eff,
  input  logic             atn,
  input  logic             eoi,
  output logic [DIO_W-1:0] dio_drive,
  output logic             oc_mode
);
  logic             idy, take_part;
  logic [DIO_W-1:0] sel_mask, drive_d;

  always_comb begin
    idy       = atn && eoi;
    take_part = idy && !cfg.unconf && (ist_eff == cfg.sense);
  end

  for (genvar i = 0; i < DIO_W; i++) begin : g_line
    always_comb sel_mask[i] = (cfg.line == LINE_W'(i));
  end

  always_comb drive_d = take_part ? sel_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dio_drive <= '0;
      oc_mode   <= 1'b0;
    end else begin
      dio_drive <= drive_d;
      oc_mode   <= idy;
    end
  end
endmodule

// File: rtl/ppoll_responder.sv
module ppoll_responder
  import ppoll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             ppcs,
  input  logic             ist_sel,
  input  logic             ist_set,
  input  logic             ist_clr,
  input  logic             srq_state,
  input  logic             srq_active,
  input  logic             atn,
  input  logic             eoi,
  output logic [DIO_W-1:0] dio_drive,
  output logic             oc_mode
);
  ppcfg_t cfg_q;
  logic   ist_eff;

  ppoll_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ppcs(ppcs), .cfg_q(cfg_q)
  );

  ppoll_ist_src u_ist (
    .clk(clk), .rst_n(rst_n), .ist_sel(ist_sel), .ist_set(ist_set),
    .ist_clr(ist_clr), .srq_state(srq_state), .srq_active(srq_active),
    .ist_eff(ist_eff)
  );

  ppoll_drive u_drv (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .ist_eff(ist_eff),
    .atn(atn), .eoi(eoi), .dio_drive(dio_drive), .oc_mode(oc_mode)
  );
endmodule

// File: rtl/ppoll_responder_chk.sv
module ppoll_responder_chk
  import ppoll_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [7:0]       cfg_wdata,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             atn,
  input logic             eoi,
  input logic [DIO_W-1:0] dio_drive,
  input logic             oc_mode,
  input ppcfg_t           cfg_q
);
  AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dio_drive)); // R3

  AST_NO_IDY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(atn && eoi) |=> (dio_drive == '0)); // R4

  AST_OC_TRACKS_IDY: assert property (@(posedge clk) disable iff (!rst_n)
    (atn && eoi) |=> oc_mode); // R5

  AST_DRIVE_NEEDS_OC: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_drive != '0) |-> oc_mode); // R5

  AST_LOCAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q == ppcfg_t'($past(cfg_wdata[CFG_W-1:0])))); // R8

  AST_UNCONF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == CMD_UNCONF && !cfg_wr) |=> cfg_q.unconf); // R7
endmodule

bind ppoll_responder ppoll_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .atn(atn), .eoi(eoi),
  .dio_drive(dio_drive), .oc_mode(oc_mode), .cfg_q(cfg_q)
);

// File: tb/ppoll_responder_tb_top.sv
`timescale 1ns/1ps
module ppoll_responder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cfg_wr = 0, cmd_valid = 0, ppcs = 0, ist_sel = 0, ist_set = 0, ist_clr = 0;
  logic srq_state = 0, srq_active = 0, atn = 0, eoi = 0;
  logic [7:0] cfg_wdata = '0, cmd_byte = '0;
  logic [7:0] dio_drive;
  logic       oc_mode;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] drv; logic oc; string tag; } exp_t;
  exp_t sbq[$];

  // requirement model state
  logic       m_u = 0, m_s = 0, m_ist = 0;
  logic [2:0] m_p = '0;

  always #2 clk = ~clk;

  ppoll_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ppcs(ppcs),
    .ist_sel(ist_sel), .ist_set(ist_set), .ist_clr(ist_clr),
    .srq_state(srq_state), .srq_active(srq_active), .atn(atn), .eoi(eoi),
    .dio_drive(dio_drive), .oc_mode(oc_mode)
  );

  function automatic logic [7:0] want_mask(logic u, logic s, logic [2:0] p,
                                           logic st, logic a, logic e);
    if (a && e && !u && (st == s)) return 8'b1 << p;
    return 8'h00;
  endfunction

  // driver: inputs set by caller at a negedge, expectation pushed, model advanced
  task automatic step(input string tag);
    exp_t e;
    logic st;
    st    = ist_sel ? (srq_state && srq_active) : m_ist;
    e.drv = want_mask(m_u, m_s, m_p, st, atn, eoi);
    e.oc  = atn && eoi;
    e.tag = tag;
    sbq.push_back(e);
    if (cfg_wr) begin
      m_u = cfg_wdata[4]; m_s = cfg_wdata[3]; m_p = cfg_wdata[2:0];
    end else if (cmd_valid && ppcs && cmd_byte[7:4] == 4'h6) begin
      m_u = 1'b0; m_s = cmd_byte[3]; m_p = cmd_byte[2:0];
    end else if (cmd_valid && ((ppcs && cmd_byte[7:4] == 4'h7) || cmd_byte == 8'h15)) begin
      m_u = 1'b1;
    end
    if (ist_set) m_ist = 1'b1;
    else if (ist_clr) m_ist = 1'b0;
    @(negedge clk);
    cfg_wr = 0; cmd_valid = 0; ist_set = 0; ist_clr = 0;
  endtask

  task automatic poll(input string tag);
    atn = 1; eoi = 1; step(tag);
    atn = 0; eoi = 0;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_cmp++;
        if (dio_drive !== e.drv || oc_mode !== e.oc) begin
          n_bad++;
          $display("FAIL %s: dio_drive=%02h oc_mode=%b expected dio_drive=%02h oc_mode=%b",
                   e.tag, dio_drive, oc_mode, e.drv, e.oc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 0;
    atn = 1; eoi = 1;
    #8;
    n_cmp++; // R1 outputs held low in reset
    if (dio_drive !== 8'h00 || oc_mode !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset dio_drive=%02h oc_mode=%b expected 00/0", dio_drive, oc_mode);
    end
    atn = 0; eoi = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    poll("R1");                                        // cleared word -> DIO1
    atn = 1; step("R4");                               // ATN alone
    eoi = 1; step("R4"); eoi = 0;                      // EOI alone
    // R2: upper bits ignored, S=1 P=1
    cfg_wr = 1; cfg_wdata = 8'hE9; step("R2");
    poll("R4");                                        // ist=0 != S
    ist_set = 1; step("R9");
    poll("R3");                                        // DIO2
    cfg_wr = 1; cfg_wdata = 8'h1C; step("R2");         // opt-out
    poll("R4");
    // R6 remote enable
    ppcs = 1; cmd_valid = 1; cmd_byte = 8'h6B; step("R6");
    poll("R6");                                        // S=1 P=3 -> 08
    ppcs = 0; cmd_valid = 1; cmd_byte = 8'h60; step("R6");
    poll("R6");                                        // still 08
    // R7 disable and unconfigure
    ppcs = 1; cmd_valid = 1; cmd_byte = 8'h75; step("R7");
    poll("R7");
    cmd_valid = 1; cmd_byte = 8'h65; step("R6");
    ist_clr = 1; step("R9");
    poll("R3");                                        // S=0 P=5 -> 20
    ppcs = 0; cmd_valid = 1; cmd_byte = 8'h15; step("R7");
    poll("R7");
    // R8 local beats remote in same cycle
    ppcs = 1; cfg_wr = 1; cfg_wdata = 8'h07; cmd_valid = 1; cmd_byte = 8'h6A; step("R8");
    ppcs = 0;
    poll("R8");                                        // S=0 P=7 -> 80
    // R9 set wins over clear
    ist_set = 1; ist_clr = 1; step("R9");
    poll("R9");                                        // ist=1 != S=0 -> 00
    cfg_wr = 1; cfg_wdata = 8'h0A; step("R2");         // S=1 P=2
    poll("R9");                                        // 04
    // R10 live service-request source
    ist_sel = 1; srq_state = 1; srq_active = 0; poll("R10");  // ist=0 -> 00
    srq_active = 1; poll("R10");                               // 04
    ist_clr = 1; step("R10");
    poll("R10");                                               // still 04
    srq_state = 0; poll("R10");                                // 00
    ist_sel = 0; poll("R10");                                  // sw bit 0 -> 00
    cfg_wr = 1; cfg_wdata = 8'h00; step("R2");
    poll("R3");                                                // 01
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule